// File: doc/BRIEF.md
# Traffic Signal Phase Sequencer

This block steps a single traffic signal through a fixed cycle of green, yellow, red and yellow. A six-state controller chooses the lamp and drives two strobes into a separate up-counter that measures phase length. One strobe clears the counter and the other lets it advance. The counter raises a done flag when its value reaches the all-ones terminal count.

Green and red each take two states. The first state lasts one cycle: it lights the lamp and clears the counter. The second state keeps the same lamp on, runs the counter, and stays until the counter reports done. Each yellow state lasts exactly one cycle. The counter width `CNT_W` sets the length of the long phases, so one full cycle of the signal takes `2^(CNT_W+1) + 4` clock cycles.

The lamp, the strobes, the done flag and the count are all brought out to ports so a supervisor can observe them.

Top module: `traffic_phase_sequencer`

## Requirements
- R1: Reset is synchronous and active-low. Any rising edge that sees `rst_n` low puts the block in its green entry state: green lamp on, `tmr_clear` high, `tmr_run` low, and `tmr_count` at 0.
- R2: The green entry state lasts exactly one cycle. In it the green lamp is on, `tmr_clear` is 1 and `tmr_run` is 0. The next state is the green wait state.
- R3: In the green wait state the green lamp stays on and `tmr_run` is 1. `tmr_count` starts at 0 and goes up by one on every cycle.
- R4: `tmr_done` is 1 exactly when `tmr_count` equals `2^CNT_W - 1`.
- R5: A cycle in the green wait state with `tmr_done` high is followed by exactly one cycle with only the yellow lamp on. The red entry state comes next.
- R6: The red entry and red wait states behave as described in R2 and R3, but light the red lamp instead of the green lamp.
- R7: A cycle in the red wait state with `tmr_done` high is followed by exactly one cycle with only the yellow lamp on. The green entry state comes next.
- R8: In every cycle exactly one of `lamp_green`, `lamp_yellow` and `lamp_red` is 1.
- R9: The counter holds its value when neither strobe is high. When running at `2^CNT_W - 1`, it wraps to 0. So `tmr_count` reads 0 in every entry and yellow cycle.
- R10: The whole cycle repeats every `2^(CNT_W+1) + 4` clock cycles.
- R11: `tmr_clear` and `tmr_run` are never both 1. Both are 0 in the yellow states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lamp_green | output | 1 | Green lamp drive |
| lamp_yellow | output | 1 | Yellow lamp drive |
| lamp_red | output | 1 | Red lamp drive |
| tmr_clear | output | 1 | Counter clear strobe from the controller |
| tmr_run | output | 1 | Counter advance strobe from the controller |
| tmr_done | output | 1 | Counter at terminal count |
| tmr_count | output | CNT_W | Current counter value |

## Verification
The bench builds two copies of the block, one with `CNT_W` = 2 and one with `CNT_W` = 3. Their full cycles are 12 and 20 clocks, so every state, every counter value and every wrap can be visited in a few dozen cycles.

Each copy is swept over several complete cycles. Every output is compared in every cycle against a position-in-cycle model computed arithmetically. Running two widths shows that the terminal count and the cycle length follow the parameter rather than a fixed value.

A reset is also applied in the middle of a long phase. This confirms that the block restarts cleanly from the green entry state.

// File: rtl/tl_pkg.sv
// Package: shared state type for the traffic phase sequencer.
// Assumes: one signal head, fixed green/yellow/red/yellow order.
package tl_pkg;

    // Controller states; each long phase has an entry and a wait state.
    typedef enum logic [2:0] {
        PH_GO_ENTRY   = 3'd0,
        PH_GO_WAIT    = 3'd1,
        PH_AMBER_A    = 3'd2,
        PH_STOP_ENTRY = 3'd3,
        PH_STOP_WAIT  = 3'd4,
        PH_AMBER_B    = 3'd5
    } phase_e;

    // Lamp selection carried from the decoder to the top.
    typedef struct packed {
        logic green;
        logic yellow;
        logic red;
    } lamps_t;

endpackage

// File: rtl/tl_phase_timer.sv
// Module: tl_phase_timer
// Up-counter that measures one long phase.
// A clear strobe wins over the run strobe. The counter wraps after its
// all-ones terminal count, which is flagged on `at_max`.
// Assumes: the strobes come from a registered controller.
module tl_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;

    // Count register: reset, clear, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (run) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Terminal count flag.
    always_comb begin
        at_max = (count_q == CNT_MAX);
    end

    assign count = count_q;

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0)); // R6

    AST_RUN_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (count_q == CNT_W'($past(count_q) + 1'b1))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(count_q)); // R9

endmodule

// File: rtl/tl_phase_fsm.sv
// Module: tl_phase_fsm
// Six-state controller for the traffic phase sequence.
// Entry states clear the timer for one cycle. Wait states run the timer
// until `done` is seen. Yellow states last one cycle.
// Assumes: `done` is the timer's terminal-count flag.
module tl_phase_fsm
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   done,
    output phase_e state,
    output logic   clr,
    output logic   run
);
    phase_e state_q;
    phase_e state_d;

    // Next-state selection for the fixed phase order.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_GO_ENTRY:   state_d = PH_GO_WAIT;
            PH_GO_WAIT:    state_d = done ? PH_AMBER_A : PH_GO_WAIT;
            PH_AMBER_A:    state_d = PH_STOP_ENTRY;
            PH_STOP_ENTRY: state_d = PH_STOP_WAIT;
            PH_STOP_WAIT:  state_d = done ? PH_AMBER_B : PH_STOP_WAIT;
            PH_AMBER_B:    state_d = PH_GO_ENTRY;
            default:       state_d = PH_GO_ENTRY;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_GO_ENTRY;
        end else begin
            state_q <= state_d;
        end
    end

    // Timer strobes decoded from the current state.
    always_comb begin
        clr = (state_q == PH_GO_ENTRY) || (state_q == PH_STOP_ENTRY);
        run = (state_q == PH_GO_WAIT)  || (state_q == PH_STOP_WAIT);
    end

    assign state = state_q;

    AST_GO_ENTRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_GO_ENTRY) |=> (state_q == PH_GO_WAIT)); // R2

    AST_GO_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_GO_WAIT && done) |=> (state_q == PH_AMBER_A)); // R5

    AST_WAIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PH_GO_WAIT || state_q == PH_STOP_WAIT) && !done)
        |=> $stable(state_q)); // R3

    AST_AMBER_A_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_AMBER_A) |=> (state_q == PH_STOP_ENTRY)); // R5

    AST_STOP_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_STOP_WAIT && done) |=> (state_q == PH_AMBER_B)); // R7

    AST_AMBER_B_TO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_AMBER_B) |=> (state_q == PH_GO_ENTRY)); // R7

endmodule

// File: rtl/tl_lamp_decode.sv
// Module: tl_lamp_decode
// Maps a controller state to a one-hot lamp set.
// An unknown encoding falls back to red, the safe aspect.
// Assumes: the state comes from tl_phase_fsm.
module tl_lamp_decode
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e state,
    output lamps_t lamps
);
    // State to lamp mapping.
    always_comb begin
        lamps = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
        unique case (state)
            PH_GO_ENTRY, PH_GO_WAIT:     lamps = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
            PH_AMBER_A, PH_AMBER_B:      lamps = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
            PH_STOP_ENTRY, PH_STOP_WAIT: lamps = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
            default:                     lamps = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
        endcase
    end

    AST_LAMPS_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lamps.green, lamps.yellow, lamps.red}) == 1); // R8

endmodule

// File: rtl/traffic_phase_sequencer.sv
// Module: traffic_phase_sequencer
// Top level: controller, phase timer and lamp decoder.
// The controller clears and runs the timer. The timer's terminal-count
// flag ends each green or red phase.
// Assumes: one clock domain, synchronous active-low reset.
module traffic_phase_sequencer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             lamp_green,
    output logic             lamp_yellow,
    output logic             lamp_red,
    output logic             tmr_clear,
    output logic             tmr_run,
    output logic             tmr_done,
    output logic [CNT_W-1:0] tmr_count
);
    import tl_pkg::*;

    phase_e state;
    lamps_t lamps;
    logic   clr;
    logic   run;
    logic   at_max;

    tl_phase_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (at_max),
        .state (state),
        .clr   (clr),
        .run   (run)
    );

    tl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .run    (run),
        .count  (tmr_count),
        .at_max (at_max)
    );

    tl_lamp_decode u_lamps (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .lamps (lamps)
    );

    // Drive the top-level outputs.
    always_comb begin
        lamp_green  = lamps.green;
        lamp_yellow = lamps.yellow;
        lamp_red    = lamps.red;
        tmr_clear   = clr;
        tmr_run     = run;
        tmr_done    = at_max;
    end

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && run)); // R11

    AST_RED_WHILE_RUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_STOP_WAIT) |-> (lamps.red && run)); // R6

endmodule

// File: tb/traffic_phase_sequencer_tb_top.sv
// Bench: two widths swept over whole cycles against an arithmetic model.
module traffic_phase_sequencer_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    logic       g2, y2, r2, c2, u2, d2;
    logic [1:0] k2;
    logic       g3, y3, r3, c3, u3, d3;
    logic [2:0] k3;

    traffic_phase_sequencer #(.CNT_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .lamp_green(g2), .lamp_yellow(y2), .lamp_red(r2),
        .tmr_clear(c2), .tmr_run(u2), .tmr_done(d2), .tmr_count(k2)
    );

    traffic_phase_sequencer #(.CNT_W(3)) dut_w3_i (
        .clk(clk), .rst_n(rst_n), .lamp_green(g3), .lamp_yellow(y3), .lamp_red(r3),
        .tmr_clear(c3), .tmr_run(u3), .tmr_done(d3), .tmr_count(k3)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare one copy against its expected outputs at cycle t after reset release.
    task automatic check_cycle(input int t, input int n, input logic g, input logic y,
                               input logic r, input logic c, input logic u,
                               input logic d, input int cnt);
        int m = 1 << n;
        int per = 2 * m + 4;
        int p = t % per;
        string tag;
        int eg = 0, ey = 0, er = 0, ec = 0, eu = 0, ek = 0;
        if (p == 0) begin
            tag = "R2"; eg = 1; ec = 1;
        end else if (p <= m) begin
            tag = "R3"; eg = 1; eu = 1; ek = p - 1;
        end else if (p == m + 1) begin
            tag = "R5"; ey = 1;
        end else if (p == m + 2) begin
            tag = "R6"; er = 1; ec = 1;
        end else if (p <= 2 * m + 2) begin
            tag = "R6"; er = 1; eu = 1; ek = p - (m + 3);
        end else begin
            tag = "R7"; ey = 1;
        end
        check(tag, "green", int'(g), eg);
        check(tag, "yellow", int'(y), ey);
        check(tag, "red", int'(r), er);
        check("R11", "clear", int'(c), ec);
        check("R11", "run", int'(u), eu);
        if (eu == 1) check("R3", "count", cnt, ek);
        else         check("R9", "count idle", cnt, 0);
        check("R4", "done", int'(d), (cnt == m - 1) ? 1 : 0);
        check("R8", "lamp count", int'(g) + int'(y) + int'(r), 1);
        if (p == 0 && t > 0) check("R10", "cycle restart", int'(g && c), 1);
    endtask

    task automatic sweep(input int cycles);
        for (int t = 0; t < cycles; t++) begin
            check_cycle(t, 2, g2, y2, r2, c2, u2, d2, int'(k2));
            check_cycle(t, 3, g3, y3, r3, c3, u3, d3, int'(k3));
            @(negedge clk);
        end
    endtask

    task automatic check_reset_state();
        check("R1", "w2 green", int'(g2), 1);
        check("R1", "w2 clear", int'(c2), 1);
        check("R1", "w2 count", int'(k2), 0);
        check("R1", "w3 green", int'(g3), 1);
        check("R1", "w3 run", int'(u3), 0);
        check("R1", "w3 count", int'(k3), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        sweep(60);
        // Reset in the middle of a long phase.
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        sweep(45);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule